// File: doc/BRIEF.md
# Triple-Redundant Scan Voter with Channel Exclusion

This block merges one data word per scan from each of three redundant processing channels into a single voted word for the application. During a scan each channel presents its word with a valid strobe; the block keeps the latest word from each channel. When the scan-end strobe arrives it compares the three words and publishes the result on the next cycle.

While all three channels are trusted, the output is the bitwise two-of-three majority. If exactly one channel disagrees with two channels that agree with each other, that channel is marked faulty. From then on it is left out of every later comparison, and the block runs on the remaining pair. A channel that gave no valid strobe during a scan counts as a disagreeing channel. When all three channels disagree, the block raises an unresolved flag and excludes no channel. If the two remaining channels disagree in two-channel mode, the block asks the whole system to go to fail-safe and freezes its outputs.

Top module: `tmr_voter`

## Requirements
- R1: After reset, `voted` is zero and `ch_fault`, `mismatch`, `degraded`, `unresolved` and `failsafe` are all low.
- R2: Results change only on the cycle after `scan_end`. In other cycles `voted` holds its value and `mismatch` is low. With all three channels in use and agreeing, `voted` equals the common word and `mismatch` stays low.
- R3: With all three channels in use and exactly one channel differing from two equal channels, `voted` is the bitwise majority, `mismatch` pulses, and bit i of `ch_fault` (channel i: 0, 1 or 2) is set for the differing channel.
- R4: A channel with no valid strobe during a scan counts as a miscompare for that scan. If the other two channels agree, the missing channel is the one marked in `ch_fault`.
- R5: With all three channels in use and no two of them agreeing, `unresolved` goes high, `mismatch` pulses, `voted` is the bitwise majority, and no channel is excluded. `unresolved` is recomputed at each scan end while three channels are in use.
- R6: Once a channel is excluded, `degraded` is high. The excluded channel's data and valid strobe have no effect, and `voted` takes the word of the remaining pair whenever that pair agrees, with no `mismatch`.
- R7: In two-channel mode, if the remaining pair differs or one of them is missing, `failsafe` goes high, `mismatch` pulses, and `voted` keeps its previous value.
- R8: While `failsafe` is high, `voted` and `ch_fault` no longer change, `mismatch` stays low, and `failsafe` stays high.
- R9: At most one `ch_fault` bit is ever set. Exclusion and `failsafe` are cleared only by reset.
- R10: A valid strobe captures that channel's word. A later strobe in the same scan replaces the earlier word. A strobe in the `scan_end` cycle counts for that scan. Captured validity is cleared once the scan ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| data0 | input | W | Channel 0 word |
| data1 | input | W | Channel 1 word |
| data2 | input | W | Channel 2 word |
| ch_valid | input | 3 | Per-channel word strobe, bit i for channel i |
| scan_end | input | 1 | Closes the scan and starts the vote |
| voted | output | W | Voted word for the application |
| ch_fault | output | 3 | Latched exclusion flag, bit i for channel i |
| mismatch | output | 1 | One-cycle pulse when a scan miscompares |
| degraded | output | 1 | High while running on two channels |
| unresolved | output | 1 | Three-way disagreement in the latest three-channel scan |
| failsafe | output | 1 | Latched request for system fail-safe |

## Verification
A wrong captured word or a stale validity bit appears on `voted` or `ch_fault` in the cycle right after the scan that uses it. So does a missed exclusion. Each such error is therefore visible within one scan. A lost exclusion flag shows up only at the next scan where the excluded channel differs: the output then follows a majority that should not exist, or two-channel mode fails to go to fail-safe. The bench therefore follows every exclusion with scans that feed garbage into the excluded channel.

// File: rtl/tmr_voter.sv
module tmr_voter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] data0,
  input  logic [W-1:0] data1,
  input  logic [W-1:0] data2,
  input  logic [2:0]   ch_valid,
  input  logic         scan_end,
  output logic [W-1:0] voted,
  output logic [2:0]   ch_fault,
  output logic         mismatch,
  output logic         degraded,
  output logic         unresolved,
  output logic         failsafe
);

  logic [W-1:0] din  [3];
  logic [W-1:0] held [3];
  logic [W-1:0] eff  [3];
  logic [2:0]   got, ev;
  logic         eq01, eq02, eq12, all_ok, pair_ok;
  logic [W-1:0] maj, pair_val;

  assign din[0] = data0;
  assign din[1] = data1;
  assign din[2] = data2;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 3; i++) held[i] <= '0;
      got <= '0;
    end else begin
      for (int i = 0; i < 3; i++)
        if (ch_valid[i]) held[i] <= din[i];
      got <= scan_end ? 3'b000 : (got | ch_valid);
    end
  end

  for (genvar g = 0; g < 3; g++) begin : g_eff
    assign eff[g] = ch_valid[g] ? din[g] : held[g];
  end
  assign ev = got | ch_valid;

  assign eq01 = ev[0] & ev[1] & (eff[0] == eff[1]);
  assign eq02 = ev[0] & ev[2] & (eff[0] == eff[2]);
  assign eq12 = ev[1] & ev[2] & (eff[1] == eff[2]);
  assign all_ok = eq01 & eq12;
  assign maj = (eff[0] & eff[1]) | (eff[0] & eff[2]) | (eff[1] & eff[2]);

  assign pair_ok  = ch_fault[0] ? eq12 : ch_fault[1] ? eq02 : eq01;
  assign pair_val = ch_fault[0] ? eff[1] : eff[0];
  assign degraded = |ch_fault;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      voted      <= '0;
      ch_fault   <= '0;
      mismatch   <= 1'b0;
      unresolved <= 1'b0;
      failsafe   <= 1'b0;
    end else begin
      mismatch <= 1'b0;
      if (scan_end && !failsafe) begin
        if (!degraded) begin
          voted      <= maj;
          mismatch   <= !all_ok;
          ch_fault   <= all_ok ? 3'b000 : {eq01, eq02, eq12};
          unresolved <= !(eq01 | eq02 | eq12);
        end else begin
          mismatch <= !pair_ok;
          if (pair_ok) voted <= pair_val;
          else         failsafe <= 1'b1;
        end
      end
    end
  end

  AST_FAULT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ch_fault)); // R9
  AST_FAULT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((ch_fault & $past(ch_fault)) == $past(ch_fault))); // R9
  AST_QUIET_NO_MISMATCH: assert property (@(posedge clk) disable iff (!rst_n)
    !scan_end |=> !mismatch); // R2
  AST_QUIET_KEEPS_VOTE: assert property (@(posedge clk) disable iff (!rst_n)
    !scan_end |=> $stable(voted)); // R2
  AST_UNRESOLVED_NO_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    unresolved |-> (ch_fault == 3'b000)); // R5
  AST_FAILSAFE_NEEDS_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
    failsafe |-> degraded); // R7
  AST_FAILSAFE_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    failsafe |=> failsafe && $stable(voted) && $stable(ch_fault) && !mismatch); // R8

endmodule

// File: tb/tmr_voter_tb_top.sv
module tmr_voter_tb_top;
  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [W-1:0] data0 = '0, data1 = '0, data2 = '0;
  logic [2:0]   ch_valid = '0;
  logic         scan_end = 1'b0;
  logic [W-1:0] voted;
  logic [2:0]   ch_fault;
  logic         mismatch, degraded, unresolved, failsafe;

  always #2.5 clk = ~clk;

  tmr_voter #(.W(W)) dut_i (
    .clk(clk), .rst_n(rst_n), .data0(data0), .data1(data1), .data2(data2),
    .ch_valid(ch_valid), .scan_end(scan_end), .voted(voted), .ch_fault(ch_fault),
    .mismatch(mismatch), .degraded(degraded), .unresolved(unresolved), .failsafe(failsafe)
  );

  typedef struct {
    logic [W-1:0] v;
    logic [2:0]   f;
    logic         m, u, fs;
    string        req;
  } exp_t;

  exp_t         q[$];
  int           checks = 0, errors = 0;
  logic [W-1:0] last_v = '0;
  bit           done = 0;

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    #1;
    if (rst_n && !done) begin
      if (scan_end) begin
        if (q.size() == 0) chk("R2", "unexpected scan", 32'd1, 32'd0);
        else begin
          exp_t e;
          e = q.pop_front();
          chk(e.req, "voted", 32'(voted), 32'(e.v));
          chk(e.req, "ch_fault", 32'(ch_fault), 32'(e.f));
          chk(e.req, "mismatch", 32'(mismatch), 32'(e.m));
          chk(e.req, "degraded", 32'(degraded), 32'(|e.f));
          chk(e.req, "unresolved", 32'(unresolved), 32'(e.u));
          chk(e.req, "failsafe", 32'(failsafe), 32'(e.fs));
          last_v = e.v;
        end
      end else begin
        chk("R2", "idle mismatch", 32'(mismatch), 32'd0);
        chk("R2", "idle voted", 32'(voted), 32'(last_v));
      end
    end
  end

  task automatic load(int ch, logic [W-1:0] d);
    @(negedge clk);
    case (ch)
      0: data0 = d;
      1: data1 = d;
      default: data2 = d;
    endcase
    ch_valid = 3'(1 << ch);
    @(negedge clk);
    ch_valid = '0;
  endtask

  task automatic scan(logic [W-1:0] d0, d1, d2, logic [2:0] v,
                      logic [W-1:0] ev, logic [2:0] ef, logic em, eu, efs, string req);
    exp_t e;
    @(negedge clk);
    data0 = d0; data1 = d1; data2 = d2;
    ch_valid = v;
    scan_end = 1'b1;
    e.v = ev; e.f = ef; e.m = em; e.u = eu; e.fs = efs; e.req = req;
    q.push_back(e);
    @(negedge clk);
    ch_valid = '0;
    scan_end = 1'b0;
  endtask

  task automatic do_reset(string req);
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    last_v = '0;
    @(negedge clk);
    chk(req, "reset voted", 32'(voted), 32'd0);
    chk(req, "reset ch_fault", 32'(ch_fault), 32'd0);
    chk(req, "reset flags", {28'd0, mismatch, degraded, unresolved, failsafe}, 32'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    do_reset("R1");
    // R10: words captured earlier in the scan
    load(0, 16'h1234); load(1, 16'h1234); load(2, 16'h1234);
    scan(16'h0, 16'h0, 16'h0, 3'b000, 16'h1234, 3'b000, 0, 0, 0, "R10");
    scan(16'hA5A5, 16'hA5A5, 16'hA5A5, 3'b111, 16'hA5A5, 3'b000, 0, 0, 0, "R2");
    scan(16'h00FF, 16'h0F0F, 16'h3333, 3'b111, 16'h033F, 3'b000, 1, 1, 0, "R5");
    scan(16'h1111, 16'h2222, 16'h1111, 3'b111, 16'h1111, 3'b010, 1, 0, 0, "R3");
    scan(16'hBEEF, 16'h0000, 16'hBEEF, 3'b111, 16'hBEEF, 3'b010, 0, 0, 0, "R6");
    scan(16'hCAFE, 16'hDEAD, 16'hCAFE, 3'b101, 16'hCAFE, 3'b010, 0, 0, 0, "R6");
    scan(16'h1000, 16'h1000, 16'h2000, 3'b111, 16'hCAFE, 3'b010, 1, 0, 1, "R7");
    scan(16'h7777, 16'h7777, 16'h7777, 3'b111, 16'hCAFE, 3'b010, 0, 0, 1, "R8");
    do_reset("R9");
    // R10: later strobe replaces earlier one; ch0 not strobed at scan end
    load(0, 16'h9999); load(0, 16'h5555);
    scan(16'h0, 16'h5555, 16'h0, 3'b010, 16'h5555, 3'b100, 1, 0, 0, "R4");
    scan(16'h4444, 16'h4444, 16'h4444, 3'b001, 16'h5555, 3'b100, 1, 0, 1, "R7");
    scan(16'h6666, 16'h6666, 16'h6666, 3'b111, 16'h5555, 3'b100, 0, 0, 1, "R8");
    repeat (3) @(negedge clk);
    chk("R9", "exclusion kept", 32'(ch_fault), 32'b100);
    chk("R2", "pending results", 32'(q.size()), 32'd0);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule